// File: doc/BRIEF.md
# Register-Programmed SPI Master Controller

This block is a single-character SPI master with six 32-bit registers on a simple synchronous register port. Software programs the character length (1 to 16 bits), clock polarity, clock phase, bit order, an internal loopback path and a two-stage clock divider through a configuration register. It then sets the enable bit and writes characters to the transmit register. Each accepted character is shifted out on `sclk`/`mosi` while `miso` is sampled. The received character is then placed in the receive register.

Progress is reported by two sticky status flags in a status register, both cleared by writing ones. The "receive ready" flag (bit 9) sets when a character has arrived. The "transmit slot free" flag (bit 8) sets whenever the single-entry transmit holding register hands its character to the shifter. An interrupt line combines the flags with a per-bit enable register. Chip selects are driven elsewhere.

Register word addresses on `reg_addr`: 0 configuration, 1 status, 2 interrupt enable, 3 command, 4 transmit, 5 receive. Configuration fields: bit 30 loopback, bit 29 clock idle-high, bit 28 late-phase sampling, bit 27 extra divide by 16, bit 26 MSB first, bit 25 master select (stored only), bit 24 enable, bits 23:20 length minus one, bits 19:16 prescale P.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, configuration reads 0, status reads 0x100 (slot-free set, ready clear), interrupt enable reads 0, `irq` is 0 and `sclk` is 0.
- R2: Configuration bits 30:16 read back exactly as written while enable (bit 24) is clear; all other bits read 0.
- R3: During a transfer the `sclk` period is 4×(P+1) system clocks, multiplied by 16 when bit 27 is set.
- R4: A configuration write made while enable is already set leaves bit 27 and bits 19:16 unchanged; the other fields still update.
- R5: While enable is clear, `sclk` rests at the level of bit 29 and writes to the transmit register are discarded (no transfer, no ready flag).
- R6: A transmit write while enabled starts a transfer. Slot-free (bit 8) sets when the character moves to the shifter. On completion the character is in the receive register and ready (bit 9) sets.
- R7: With bit 26 set, `mosi` carries the character MSB first, otherwise LSB first; with bits 29:28 = 00, `miso` is captured on rising `sclk`.
- R8: With bit 30 set, `mosi` is looped to the receive shifter in place of `miso`, for either phase and polarity.
- R9: The receive register is right-justified to length+1 bits with the upper bits zero; transmit bits above the length are ignored.
- R10: Writing 1 to a status bit clears it; writing 0 leaves it unchanged.
- R11: `irq` is the OR of (status bit AND interrupt-enable bit) over bits 9 and 8.
- R12: Writes to the command register, including bit 22, have no effect: it reads 0 and transfers are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `miso` is a settled level at every system clock edge and that `rst_n` is held low across at least one edge. They also assume that `reg_wr` is a single-cycle strobe whose address and data are stable at that edge. The bench drives every register access and `miso` change away from the active clock edge. It uses a `miso` responder that shifts only on the trailing serial clock edge. It changes the divider only by the clear-enable, write, re-enable sequence, except in the one scenario that deliberately checks that a divider write with enable set is dropped.

// File: rtl/spim_pkg.sv
// Package: shared register addresses and field positions for the SPI master.
// Assumes 32-bit registers; field positions are fixed by the software view.
package spim_pkg;
    localparam int LEN_W = 4;             // character length field width
    localparam int PM_W  = 4;             // prescale field width
    localparam int DIV_SH = 4;            // extra divider is 2**DIV_SH
    localparam int CHAR_W = 1 << LEN_W;   // widest character

    typedef enum logic [2:0] {
        A_CFG  = 3'd0,
        A_STAT = 3'd1,
        A_IEN  = 3'd2,
        A_CMD  = 3'd3,
        A_TX   = 3'd4,
        A_RX   = 3'd5
    } spim_addr_e;

    localparam int B_LOOP  = 30;
    localparam int B_CINV  = 29;
    localparam int B_LATE  = 28;
    localparam int B_D16   = 27;
    localparam int B_MSBF  = 26;
    localparam int B_EN    = 24;
    localparam int B_LEN_L = 20;
    localparam int B_PM_L  = 16;
    localparam int B_RDY   = 9;
    localparam int B_FREE  = 8;

    localparam logic [31:0] CFG_WMASK = 32'h7FFF_0000;
    localparam logic [31:0] CFG_DMASK = 32'h080F_0000;
endpackage

// File: rtl/spim_clkdiv.sv
// Module: half-period tick generator for the serial clock.
// Emits one tick every 2*(pm+1) clocks, or 2*(pm+1)*2**DS with div16;
// the count restarts whenever run is low so the first tick is a full half.
module spim_clkdiv #(
    parameter int PW = 4,
    parameter int DS = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [PW-1:0] pm,
    input  logic          div16,
    output logic          tick
);
    localparam int CNT_W = PW + DS + 2;

    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] half_m1;
    logic [CNT_W-1:0] cnt_q;

    // Derive the terminal count from the divider settings.
    always_comb begin
        base    = CNT_W'(pm) + 1'b1;
        half_m1 = (div16 ? (base << (DS + 1)) : (base << 1)) - 1'b1;
    end

    // Count system clocks within one half period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)       cnt_q <= '0;
        else if (cnt_q == half_m1) cnt_q <= '0;
        else                       cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == half_m1);
endmodule

// File: rtl/spim_engine.sv
// Module: one-character shift engine with selectable phase, polarity and order.
// Assumes start is only raised when en is high; tick marks each serial edge.
module spim_engine #(
    parameter int LW = 4,
    localparam int CW = 1 << LW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          start,
    input  logic [CW-1:0] tx_char,
    input  logic [LW-1:0] len,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          msbf,
    input  logic          loop,
    input  logic          tick,
    input  logic          miso,
    output logic          busy,
    output logic          done,
    output logic [CW-1:0] rx_char,
    output logic          sclk,
    output logic          mosi
);
    logic          busy_q, done_q, sclk_q;
    logic [LW:0]   edge_q;
    logic [LW-1:0] bidx_q;
    logic [CW-1:0] tx_q, rx_q, rx_out_q, rx_nxt;
    logic [LW-1:0] pos;
    logic          lead, last, rx_in, sample, advance;

    // Decode the current edge and the bit position in play.
    always_comb begin
        lead    = ~edge_q[0];
        last    = (edge_q == {len, 1'b1});
        pos     = msbf ? (len - bidx_q) : bidx_q;
        mosi    = busy_q & tx_q[pos];
        rx_in   = loop ? mosi : miso;
        sample  = busy_q & tick & (lead ^ cpha);
        advance = busy_q & tick & ~last &
                  (cpha ? (lead && (edge_q != '0)) : ~lead);
        rx_nxt  = rx_q;
        if (sample) rx_nxt[pos] = rx_in;
    end

    // Sequence one character through its 2*(len+1) serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q   <= 1'b0;
            done_q   <= 1'b0;
            edge_q   <= '0;
            bidx_q   <= '0;
            tx_q     <= '0;
            rx_q     <= '0;
            rx_out_q <= '0;
        end else begin
            done_q <= 1'b0;
            if (!en) begin
                busy_q <= 1'b0;
            end else if (start && !busy_q) begin
                busy_q <= 1'b1;
                edge_q <= '0;
                bidx_q <= '0;
                tx_q   <= tx_char;
                rx_q   <= '0;
            end else if (busy_q && tick) begin
                rx_q   <= rx_nxt;
                edge_q <= edge_q + 1'b1;
                if (advance) bidx_q <= bidx_q + 1'b1;
                if (last) begin
                    busy_q   <= 1'b0;
                    done_q   <= 1'b1;
                    rx_out_q <= rx_nxt;
                end
            end
        end
    end

    // Toggle the serial clock on each edge tick, rest at cpol when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)              sclk_q <= 1'b0;
        else if (busy_q && tick) sclk_q <= ~sclk_q;
        else if (!busy_q)        sclk_q <= cpol;
    end

    assign busy    = busy_q;
    assign done    = done_q;
    assign rx_char = rx_out_q;
    assign sclk    = sclk_q;

    a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !busy_q);
    a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(busy_q) && !busy_q) |-> (sclk_q == $past(cpol)));
    a_r6_bit_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> (bidx_q <= len));
endmodule

// File: rtl/spim_ctrl.sv
// Module: register front end of the SPI master (top).
// Holds configuration, status, interrupt enable and the one-entry transmit
// slot; reads are combinational, writes take effect at the strobe edge.
module spim_ctrl
    import spim_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [2:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    output logic          sclk,
    output logic          mosi,
    input  logic          miso,
    output logic          irq
);
    logic [DW-1:0]     cfg_q, cfg_nxt;
    logic              st_rdy, st_free;
    logic [1:0]        ien_q;
    logic [CHAR_W-1:0] hold_q;
    logic              hold_full;
    logic              en, busy, done, start, tick;
    logic [CHAR_W-1:0] rx_char;

    assign en    = cfg_q[B_EN];
    assign start = en && hold_full && !busy;

    // Merge a configuration write, keeping the divider while enabled.
    always_comb begin
        cfg_nxt = reg_wdata & CFG_WMASK;
        if (en) cfg_nxt = (cfg_nxt & ~CFG_DMASK) | (cfg_q & CFG_DMASK);
    end

    // Update the configuration and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            ien_q <= '0;
        end else if (reg_wr) begin
            if (reg_addr == A_CFG) cfg_q <= cfg_nxt;
            if (reg_addr == A_IEN) ien_q <= {reg_wdata[B_RDY], reg_wdata[B_FREE]};
        end
    end

    // Status flags: set events win over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_rdy  <= 1'b0;
            st_free <= 1'b1;
        end else begin
            if (done)                                              st_rdy <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[B_RDY]) st_rdy <= 1'b0;
            if (start)                                              st_free <= 1'b1;
            else if (reg_wr && reg_addr == A_STAT && reg_wdata[B_FREE]) st_free <= 1'b0;
        end
    end

    // One-entry transmit slot: filled by a write, emptied into the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q    <= '0;
            hold_full <= 1'b0;
        end else if (!en) begin
            hold_full <= 1'b0;
        end else if (start) begin
            hold_full <= 1'b0;
        end else if (reg_wr && reg_addr == A_TX && !hold_full) begin
            hold_q    <= reg_wdata[CHAR_W-1:0];
            hold_full <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CFG:  reg_rdata = cfg_q;
            A_STAT: begin
                reg_rdata[B_RDY]  = st_rdy;
                reg_rdata[B_FREE] = st_free;
            end
            A_IEN: begin
                reg_rdata[B_RDY]  = ien_q[1];
                reg_rdata[B_FREE] = ien_q[0];
            end
            A_RX:   reg_rdata[CHAR_W-1:0] = rx_char;
            default: reg_rdata = '0;
        endcase
    end

    assign irq = (st_rdy & ien_q[1]) | (st_free & ien_q[0]);

    spim_clkdiv #(.PW(PM_W), .DS(DIV_SH)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .pm    (cfg_q[B_PM_L +: PM_W]),
        .div16 (cfg_q[B_D16]),
        .tick  (tick)
    );

    spim_engine #(.LW(LEN_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (en),
        .start   (start),
        .tx_char (hold_q),
        .len     (cfg_q[B_LEN_L +: LEN_W]),
        .cpol    (cfg_q[B_CINV]),
        .cpha    (cfg_q[B_LATE]),
        .msbf    (cfg_q[B_MSBF]),
        .loop    (cfg_q[B_LOOP]),
        .tick    (tick),
        .miso    (miso),
        .busy    (busy),
        .done    (done),
        .rx_char (rx_char),
        .sclk    (sclk),
        .mosi    (mosi)
    );

    a_r4_div_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en)) |-> ($stable(cfg_q[B_D16]) && $stable(cfg_q[B_PM_L +: PM_W])));
    a_r6_rdy_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> st_rdy);
    a_r6_slot_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_full && !busy && en) |=> (!hold_full && st_free && busy));
endmodule

// File: tb/spim_ctrl_bench.sv
module spim_ctrl_bench;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = 3'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sclk, mosi, irq;
    logic        miso;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    logic [7:0]  slv_sr = 8'h00;
    logic [7:0]  slv_word = 8'h00;
    logic        slv_load = 1'b0;
    logic [15:0] cap = '0;

    always #(CLK_P/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    spim_ctrl u_spim_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sclk(sclk),
        .mosi(mosi), .miso(miso), .irq(irq)
    );

    // responder: shifts on falling sclk, loads on request
    always @(negedge sclk or posedge slv_load) begin
        if (slv_load) slv_sr <= slv_word;
        else          slv_sr <= {slv_sr[6:0], 1'b0};
    end
    assign miso = slv_sr[7];

    // observe mosi at rising sclk
    always @(posedge sclk) cap <= {cap[14:0], mosi};

    function automatic logic [31:0] cfgw(input bit lp, input bit ci, input bit ph,
            input bit d16, input bit msb, input bit en, input int len, input int pm);
        logic [31:0] w = '0;
        w[30] = lp; w[29] = ci; w[28] = ph; w[27] = d16; w[26] = msb; w[24] = en;
        w[23:20] = 4'(len - 1);
        w[19:16] = 4'(pm);
        return w;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_rdy(input string req);
        logic [31:0] s;
        for (int i = 0; i < 20000; i++) begin
            rd(3'd1, s);
            if (s[9]) return;
        end
        chk(req, 32'h0, 32'h200);
    endtask

    task automatic xfer(input logic [31:0] cfg, input logic [31:0] txd, output logic [31:0] rxd);
        wr(3'd0, cfg & ~32'h0100_0000);
        wr(3'd0, cfg);
        wr(3'd1, 32'h300);
        wr(3'd4, txd);
        wait_rdy("R6");
        rd(3'd5, rxd);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk("R1 cfg", v, 32'h0);
        rd(3'd1, v); chk("R1 status", v, 32'h100);
        rd(3'd2, v); chk("R1 ien", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 sclk", {31'b0, sclk}, 32'h0);
    endtask

    task automatic t_fields();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF & ~32'h0100_0000);
        rd(3'd0, v); chk("R2 fields", v, 32'h7EFF_0000);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_divlock();
        logic [31:0] v;
        wr(3'd0, cfgw(0,0,0,0,1,1,8,1));
        wr(3'd0, cfgw(0,0,0,1,1,1,4,6));
        rd(3'd0, v);
        chk("R4 divider held", {24'b0, v[27], v[19:16]}, 32'h1);
        chk("R4 length updates", {28'b0, v[23:20]}, 32'h3);
        wr(3'd0, cfgw(0,0,0,0,1,0,8,1));
        wr(3'd0, cfgw(0,0,0,1,1,0,8,6));
        rd(3'd0, v);
        chk("R4 divider taken when off", {24'b0, v[27], v[19:16]}, 32'h16);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        wr(3'd0, cfgw(0,1,0,0,1,0,8,0));
        wr(3'd1, 32'h300);
        @(negedge clk);
        chk("R5 idle high", {31'b0, sclk}, 32'h1);
        wr(3'd4, 32'h55);
        repeat (200) @(negedge clk);
        rd(3'd1, v);
        chk("R5 no transfer", v, 32'h0);
        chk("R5 still idle", {31'b0, sclk}, 32'h1);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_period(input logic [31:0] cfg, input int exp, input string req);
        logic [31:0] v;
        int t1 = 0;
        int rises = 0;
        logic prev;
        wr(3'd0, cfg & ~32'h0100_0000);
        wr(3'd0, cfg);
        wr(3'd1, 32'h300);
        wr(3'd4, 32'h3);
        prev = sclk;
        for (int i = 0; i < 5000 && rises < 2; i++) begin
            @(negedge clk);
            if (!prev && sclk) begin
                rises++;
                if (rises == 1) t1 = cyc;
                else chk(req, 32'(cyc - t1), 32'(exp));
            end
            prev = sclk;
        end
        if (rises < 2) chk(req, 32'(rises), 32'd2);
        wait_rdy(req);
        wr(3'd0, 32'h0);
    endtask

    task automatic t_responder();
        logic [31:0] v, s;
        wr(3'd0, cfgw(0,0,0,0,1,0,8,1));
        slv_word = 8'hA5;
        @(negedge clk); slv_load = 1'b1;
        @(negedge clk); slv_load = 1'b0;
        xfer(cfgw(0,0,0,0,1,1,8,1), 32'h5A, v);
        chk("R7 miso captured", v, 32'hA5);
        chk("R7 msb first on mosi", {24'b0, cap[7:0]}, 32'h5A);
        rd(3'd1, s);
        chk("R6 ready and slot free", s, 32'h300);
        xfer(cfgw(0,0,0,0,0,1,8,1), 32'h01, v);
        chk("R7 lsb first on mosi", {24'b0, cap[7:0]}, 32'h80);
    endtask

    task automatic t_loop();
        logic [31:0] v;
        xfer(cfgw(1,1,1,0,0,1,5,0), 32'hFFFF_FFF3, v);
        chk("R8 R9 loop late phase 5-bit", v, 32'h13);
        xfer(cfgw(1,0,0,0,1,1,16,0), 32'hBEEF, v);
        chk("R8 loop 16-bit", v, 32'hBEEF);
        xfer(cfgw(1,1,0,0,1,1,3,2), 32'h6, v);
        chk("R9 3-bit right-justified", v, 32'h6);
    endtask

    task automatic t_w1c();
        logic [31:0] v;
        wr(3'd1, 32'h0);
        rd(3'd1, v); chk("R10 zero write keeps", v, 32'h300);
        wr(3'd1, 32'h200);
        rd(3'd1, v); chk("R10 clear ready only", v, 32'h100);
        wr(3'd1, 32'h100);
        rd(3'd1, v); chk("R10 clear slot free", v, 32'h0);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        xfer(cfgw(1,0,0,0,1,1,8,0), 32'h11, v);
        wr(3'd2, 32'h0);
        @(negedge clk); chk("R11 masked", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h200);
        @(negedge clk); chk("R11 ready enabled", {31'b0, irq}, 32'h1);
        wr(3'd1, 32'h200);
        @(negedge clk); chk("R11 cleared", {31'b0, irq}, 32'h0);
        wr(3'd2, 32'h100);
        @(negedge clk); chk("R11 slot free enabled", {31'b0, irq}, 32'h1);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_cmd();
        logic [31:0] v;
        wr(3'd3, 32'h0040_0000);
        rd(3'd3, v); chk("R12 command reads 0", v, 32'h0);
        xfer(cfgw(1,0,0,0,1,1,8,0), 32'h69, v);
        chk("R12 transfer unchanged", v, 32'h69);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fields();
        t_divlock();
        t_disabled();
        t_period(cfgw(1,0,0,0,1,1,8,2), 12, "R3 pm=2");
        t_period(cfgw(1,0,0,1,1,1,2,0), 64, "R3 div16");
        t_responder();
        t_loop();
        t_w1c();
        t_irq();
        t_cmd();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule